// File: doc/BRIEF.md
# Moore Serial Pattern Detector

This block watches a one-bit serial stream and raises a flag once the four most recently sampled bits, oldest first, are 1, 1, 0, 1. Sampling does not happen on every clock: a step strobe marks the clock edges on which the input bit counts. The strobe is expected to come from a source that is already debounced and synchronized to the clock.

The detector is a five-state Moore machine. Its states are: nothing matched, "1" seen, "11" seen, "110" seen, and pattern found. The output depends only on the present state. A match sends the machine back into the partial-match states, so one match can share bits with the next. A control module holds the state register and the next-state logic. It passes a small struct of strobes to a datapath module, which holds the registered flag.

Top module: `seq_detect_moore`

## Requirements
- R1: Asserting `clr` (active high) forces the machine to the no-match state and drives `detect` to 0 at once, with no clock edge needed.
- R2: On a rising clock edge with `stepEn` low, the state and `detect` do not change, whatever `serialIn` does.
- R3: `detect` goes to 1 on the step edge that samples the final 1 of a 1,1,0,1 run, and it is 0 after every step edge that does not complete the pattern.
- R4: `detect` stays high until the next step edge. If that step does not complete another match, `detect` returns to 0.
- R5: From the found state a sampled 1 leads to the "11" state, so a following 0,1 produces a second detection (overlap).
- R6: From the found state a sampled 0 leads to the no-match state, so a following 1,0,1 produces no detection.
- R7: From the "11" state a sampled 1 stays in "11", so any run of three or more 1s followed by 0,1 is detected.
- R8: From the "110" state a sampled 0 leads to the no-match state, so a following 1 produces no detection.
- R9: From the no-match state a 0 stays put and a 1 leads to "1". From "1", a 0 returns to no-match, so 1,0,1,0,1 produces no detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling occurs on its rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| stepEn | input | 1 | Step strobe; the input is sampled only when this is high |
| serialIn | input | 1 | Serial data bit |
| detect | output | 1 | High while the machine is in the found state |

## Verification
Any state error shows up only through `detect`. A wrong transition from "110" or from the found state turns a due detection into a missing pulse, or produces an extra pulse, within one to four steps. A wrong transition from no-match, "1" or "11" can stay hidden until the next completed or almost completed pattern. The stimulus therefore drives long runs of 1s, runs broken one bit short, and matches that share bits, so every transition ends in a visible result within a few steps. Hold behaviour is checked by leaving the machine in the found state with the strobe low. A changed state would appear as a flag that drops without a step.

// File: rtl/seq_detect_pkg.sv
package seq_detect_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_TAIL0 = 3'd3,
    ST_FOUND = 3'd4
  } seqState_t;

  typedef struct packed {
    logic step;
    logic enterFound;
  } seqStrobe_t;

endpackage

// File: rtl/seq_detect_ctrl.sv
module seq_detect_ctrl
  import seq_detect_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       stepEn,
  input  logic       serialIn,
  output seqState_t  curState,
  output seqStrobe_t strobe
);

  seqState_t nxtState;

  always_comb begin
    nxtState = ST_IDLE;
    case (curState)
      ST_IDLE:  nxtState = serialIn ? ST_ONE   : ST_IDLE;
      ST_ONE:   nxtState = serialIn ? ST_TWO   : ST_IDLE;
      ST_TWO:   nxtState = serialIn ? ST_TWO   : ST_TAIL0;
      ST_TAIL0: nxtState = serialIn ? ST_FOUND : ST_IDLE;
      ST_FOUND: nxtState = serialIn ? ST_TWO   : ST_IDLE;
      default:  nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr)         curState <= ST_IDLE;
    else if (stepEn) curState <= nxtState;
  end

  always_comb begin
    strobe.step       = stepEn;
    strobe.enterFound = (nxtState == ST_FOUND);
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (clr)
    !stepEn |=> $stable(curState));

  assert_complete_R3: assert property (@(posedge clk) disable iff (clr)
    (stepEn && curState == ST_TAIL0 && serialIn) |=> curState == ST_FOUND);

  assert_overlap_R5: assert property (@(posedge clk) disable iff (clr)
    (stepEn && curState == ST_FOUND && serialIn) |=> curState == ST_TWO);

  assert_drop_R6: assert property (@(posedge clk) disable iff (clr)
    (stepEn && curState == ST_FOUND && !serialIn) |=> curState == ST_IDLE);

  assert_run_R7: assert property (@(posedge clk) disable iff (clr)
    (stepEn && curState == ST_TWO && serialIn) |=> curState == ST_TWO);

  assert_break_R8: assert property (@(posedge clk) disable iff (clr)
    (stepEn && curState == ST_TAIL0 && !serialIn) |=> curState == ST_IDLE);

  assert_legal_R9: assert property (@(posedge clk) disable iff (clr)
    curState inside {ST_IDLE, ST_ONE, ST_TWO, ST_TAIL0, ST_FOUND});

endmodule

// File: rtl/seq_detect_dpath.sv
module seq_detect_dpath
  import seq_detect_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  seqStrobe_t strobe,
  output logic       flag
);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)              flag <= 1'b0;
    else if (strobe.step) flag <= strobe.enterFound;
  end

  assert_flag_hold_R2: assert property (@(posedge clk) disable iff (clr)
    !strobe.step |=> $stable(flag));

  assert_flag_pulse_R4: assert property (@(posedge clk) disable iff (clr)
    (flag && strobe.step && !strobe.enterFound) |=> !flag);

endmodule

// File: rtl/seq_detect_moore.sv
module seq_detect_moore
  import seq_detect_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic stepEn,
  input  logic serialIn,
  output logic detect
);

  seqState_t  curState;
  seqStrobe_t strobe;

  seq_detect_ctrl u_ctrl (
    .clk      (clk),
    .clr      (clr),
    .stepEn   (stepEn),
    .serialIn (serialIn),
    .curState (curState),
    .strobe   (strobe)
  );

  seq_detect_dpath u_dpath (
    .clk    (clk),
    .clr    (clr),
    .strobe (strobe),
    .flag   (detect)
  );

  // Flag register and state register are separate; they must agree.
  assert_flag_state_R3: assert property (@(posedge clk) disable iff (clr)
    detect == (curState == ST_FOUND));

  assert_clear_R1: assert property (@(posedge clk)
    clr |-> (!detect && curState == ST_IDLE));

endmodule

// File: tb/tb_seq_detect_moore.sv
module tb_seq_detect_moore;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic stepEn = 1'b0;
  logic serialIn = 1'b0;
  logic detect;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seq_detect_moore dut (
    .clk(clk), .clr(clr), .stepEn(stepEn), .serialIn(serialIn), .detect(detect)
  );

  // {input bit, expected detect after that step}
  localparam int NVEC = 28;
  localparam logic [1:0] VEC [0:NVEC-1] = '{
    2'b10, 2'b10, 2'b00, 2'b11, 2'b10, 2'b00, 2'b11, 2'b00,
    2'b10, 2'b10, 2'b10, 2'b00, 2'b11, 2'b00, 2'b00, 2'b10,
    2'b10, 2'b00, 2'b11, 2'b10, 2'b00, 2'b00, 2'b10, 2'b00,
    2'b10, 2'b10, 2'b00, 2'b11
  };

  task automatic check(input string req, input logic expv);
    checks++;
    if (detect !== expv) begin
      fails++;
      $display("FAIL %s: detect=%b expected=%b at %0t", req, detect, expv, $time);
    end
  endtask

  task automatic step(input logic b);
    @(negedge clk);
    stepEn = 1'b1;
    serialIn = b;
    @(negedge clk);
    stepEn = 1'b0;
  endtask

  task automatic stepChk(input logic b, input logic expv, input string req);
    step(b);
    check(req, expv);
  endtask

  task automatic doClear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #3;
    check("R1", 1'b0);
    repeat (2) @(negedge clk);
    clr = 1'b0;
    check("R1", 1'b0);

    // Table walk (R3)
    for (int i = 0; i < NVEC; i++) stepChk(VEC[i][1], VEC[i][0], "R3");

    // R4: flag holds until next step, then drops
    doClear();
    stepChk(1, 0, "R4"); stepChk(1, 0, "R4"); stepChk(0, 0, "R4"); stepChk(1, 1, "R4");
    stepChk(0, 0, "R4");

    // R2: no step, toggling input, found state held
    doClear();
    step(1); step(1); step(0); step(1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      serialIn = k[0];
      check("R2", 1'b1);
    end
    @(negedge clk);
    check("R2", 1'b1);
    stepChk(1, 0, "R2");
    stepChk(0, 0, "R2");
    stepChk(1, 1, "R2");

    // R5: overlap
    doClear();
    step(1); step(1); step(0); stepChk(1, 1, "R5");
    stepChk(1, 0, "R5"); stepChk(0, 0, "R5"); stepChk(1, 1, "R5");

    // R6: found then 0 goes to idle
    doClear();
    step(1); step(1); step(0); stepChk(1, 1, "R6");
    stepChk(0, 0, "R6"); stepChk(1, 0, "R6"); stepChk(0, 0, "R6"); stepChk(1, 0, "R6");

    // R7: long run of ones
    doClear();
    stepChk(1, 0, "R7"); stepChk(1, 0, "R7"); stepChk(1, 0, "R7"); stepChk(1, 0, "R7");
    stepChk(1, 0, "R7"); stepChk(0, 0, "R7"); stepChk(1, 1, "R7");

    // R8: 110 then 0 goes to idle
    doClear();
    step(1); step(1); step(0);
    stepChk(0, 0, "R8"); stepChk(1, 0, "R8"); stepChk(0, 0, "R8"); stepChk(1, 0, "R8");

    // R9: idle and "1" transitions
    doClear();
    stepChk(0, 0, "R9"); stepChk(0, 0, "R9");
    stepChk(1, 0, "R9"); stepChk(0, 0, "R9"); stepChk(1, 0, "R9"); stepChk(0, 0, "R9");
    stepChk(1, 0, "R9");
    stepChk(1, 0, "R9"); stepChk(0, 0, "R9"); stepChk(1, 1, "R9");

    // R1: asynchronous clear while found, no clock edge
    doClear();
    step(1); step(1); step(0); stepChk(1, 1, "R1");
    #2 clr = 1'b1;
    #1 check("R1", 1'b0);
    @(negedge clk);
    clr = 1'b0;
    check("R1", 1'b0);
    stepChk(0, 0, "R1"); stepChk(1, 0, "R1");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule